// File: doc/BRIEF.md
# SDRAM Mode-Register Write Decoder

This block sits between a processor-style bus and the command side of an SDRAM controller. It watches bus writes for two reserved 4 KB address windows, one for each SDRAM area. A write that lands in a window does not use its write data. The mode value is the low address offset of the write. The block realigns that offset to the SDRAM address pins and sends a one-cycle mode-set request to the matching area. It then holds bus ready low until the command side acknowledges.

The block also keeps a "programmed" flag for each area. Normal accesses to an area whose mode has not yet been set are stopped and reported on an error output. All other bus traffic goes through to the normal access path in the same cycle, unchanged.

Top module: `sdmr_mrs_dec`

## Requirements
- R1: After a synchronous reset, `bus_rdy_o` is 1, `mrs_req_o` is 0 and `bus_err_o` is 0, and both areas are unprogrammed.
- R2: A write to 0xFFFFD000+X selects area code 0 (the first area). A write to 0xFFFFE000+X selects area code 1 (the second area). The code is driven on `mrs_area_o`.
- R3: The mode value comes only from the offset X; `bus_wdata_i` has no effect. In wide mode (`bus_wide_i`=1) `mrs_val_o` equals X>>2. For example, a write to 0xFFFFD8C0 gives 0x230.
- R4: In narrow mode (`bus_wide_i`=0) `mrs_val_o` equals X>>1. The mode select is taken only while reset is high. Changing it after reset has no effect.
- R5: A window write whose offset is above 0xFFC issues no command, is not forwarded, and leaves `bus_rdy_o` at 1.
- R6: A read inside either window issues no command, is not forwarded, and returns no mode contents.
- R7: `mrs_req_o` is high for exactly one cycle, in the cycle after the accepted window write. `bus_rdy_o` is low from that cycle until the cycle after `mrs_ack_i` is seen high.
- R8: An area's flag is set when its command is acknowledged. Area code 0 covers 0x08000000–0x0BFFFFFF and area code 1 covers 0x0C000000–0x0FFFFFFF. An access to an unprogrammed area is not forwarded, and `bus_err_o` goes high for one cycle, in the next cycle.
- R9: An access outside both windows and not blocked by R8 appears on the `fwd_*` outputs in the same cycle, with address, data and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wide_i | input | 1 | 1 = 32-bit bus (shift by 2), 0 = 16-bit bus (shift by 1); sampled in reset |
| bus_req_i | input | 1 | Bus access strobe, accepted when `bus_rdy_o` is 1 |
| bus_we_i | input | 1 | 1 = write |
| bus_addr_i | input | 32 | Bus address |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdy_o | output | 1 | Block can accept an access |
| bus_err_o | output | 1 | One-cycle pulse: access to an unprogrammed area |
| fwd_req_o | output | 1 | Forwarded normal access strobe |
| fwd_we_o | output | 1 | Forwarded direction |
| fwd_addr_o | output | 32 | Forwarded address |
| fwd_wdata_o | output | 32 | Forwarded write data |
| mrs_req_o | output | 1 | Mode-set command request |
| mrs_area_o | output | 1 | Target area code |
| mrs_val_o | output | 12 | Realigned mode value for the SDRAM address pins |
| mrs_ack_i | input | 1 | Command side acknowledge |

## Verification
The hardest state to reach from the ports is the narrow-bus alignment while the width input disagrees with its value at reset. The bench holds the narrow setting through a reset and then raises the select. It then programs both areas and expects the one-bit shift. The bench also delays acknowledges by different numbers of cycles, so it sees ready held low over several idle cycles. It checks that an area stays blocked until the acknowledge for that area, not for the other one.

// File: rtl/sdmr_pkg.sv
package sdmr_pkg;
  localparam int N_AREA = 2;
  localparam int AIDX_W = (N_AREA > 1) ? $clog2(N_AREA) : 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } mrs_st_t;
endpackage

// File: rtl/sdmr_win_dec.sv
module sdmr_win_dec
  import sdmr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W = 12,
  parameter logic [OFS_W-1:0] MAX_OFS = 12'hFFC,
  parameter logic [N_AREA-1:0][ADDR_W-1:0] WIN_BASE = {32'hFFFF_E000, 32'hFFFF_D000}
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output logic              hit_o,
  output logic              ofs_ok_o,
  output logic [AIDX_W-1:0] area_o,
  output logic [OFS_W-1:0]  val_o
);
  logic [N_AREA-1:0] hit_v;
  logic [OFS_W-1:0]  ofs;

  assign ofs = addr_i[OFS_W-1:0];

  for (genvar k = 0; k < N_AREA; k++) begin : g_win
    assign hit_v[k] = (addr_i[ADDR_W-1:OFS_W] == WIN_BASE[k][ADDR_W-1:OFS_W]);
  end

  always_comb begin
    area_o = '0;
    for (int k = 0; k < N_AREA; k++)
      if (hit_v[k]) area_o = AIDX_W'(k);
  end

  assign hit_o    = |hit_v;
  assign ofs_ok_o = (ofs <= MAX_OFS);
  assign val_o    = wide_i ? (ofs >> 2) : (ofs >> 1);
endmodule

// File: rtl/sdmr_area_gate.sv
module sdmr_area_gate
  import sdmr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int AREA_SH = 26,
  parameter logic [N_AREA-1:0][ADDR_W-1:0] AREA_BASE = {32'h0C00_0000, 32'h0800_0000}
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_AREA-1:0] prog_i,
  output logic              blocked_o
);
  logic [N_AREA-1:0] in_area;

  for (genvar k = 0; k < N_AREA; k++) begin : g_area
    assign in_area[k] = (addr_i[ADDR_W-1:AREA_SH] == AREA_BASE[k][ADDR_W-1:AREA_SH]);
  end

  assign blocked_o = |(in_area & ~prog_i);
endmodule

// File: rtl/sdmr_cmd_fsm.sv
module sdmr_cmd_fsm
  import sdmr_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [AIDX_W-1:0] area_i,
  input  logic [OFS_W-1:0]  val_i,
  input  logic              ack_i,
  input  logic              blk_i,
  output logic              rdy_o,
  output logic              err_o,
  output logic              req_o,
  output logic [AIDX_W-1:0] area_o,
  output logic [OFS_W-1:0]  val_o,
  output logic [N_AREA-1:0] prog_o
);
  mrs_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      req_o  <= 1'b0;
      err_o  <= 1'b0;
      area_o <= '0;
      val_o  <= '0;
      prog_o <= '0;
    end else begin
      req_o <= 1'b0;
      err_o <= blk_i;
      case (st)
        ST_IDLE: if (go_i) begin
          st     <= ST_WAIT;
          req_o  <= 1'b1;
          area_o <= area_i;
          val_o  <= val_i;
        end
        ST_WAIT: if (ack_i) begin
          prog_o[area_o] <= 1'b1;
          st             <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rdy_o = (st == ST_IDLE);
endmodule

// File: rtl/sdmr_mrs_dec.sv
module sdmr_mrs_dec
  import sdmr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W = 12,
  parameter logic [OFS_W-1:0] MAX_OFS = 12'hFFC,
  parameter int AREA_SH = 26,
  parameter logic [N_AREA-1:0][ADDR_W-1:0] WIN_BASE = {32'hFFFF_E000, 32'hFFFF_D000},
  parameter logic [N_AREA-1:0][ADDR_W-1:0] AREA_BASE = {32'h0C00_0000, 32'h0800_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wide_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_rdy_o,
  output logic              bus_err_o,
  output logic              fwd_req_o,
  output logic              fwd_we_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic [DATA_W-1:0] fwd_wdata_o,
  output logic              mrs_req_o,
  output logic [AIDX_W-1:0] mrs_area_o,
  output logic [OFS_W-1:0]  mrs_val_o,
  input  logic              mrs_ack_i
);
  logic              wide_q;
  logic              win_hit, ofs_ok, blocked, acc;
  logic [AIDX_W-1:0] win_area;
  logic [OFS_W-1:0]  win_val;
  logic [N_AREA-1:0] prog_q;

  always_ff @(posedge clk) begin
    if (rst) wide_q <= bus_wide_i;
  end

  sdmr_win_dec #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .MAX_OFS(MAX_OFS), .WIN_BASE(WIN_BASE)
  ) u_win (
    .addr_i(bus_addr_i), .wide_i(wide_q), .hit_o(win_hit),
    .ofs_ok_o(ofs_ok), .area_o(win_area), .val_o(win_val)
  );

  sdmr_area_gate #(
    .ADDR_W(ADDR_W), .AREA_SH(AREA_SH), .AREA_BASE(AREA_BASE)
  ) u_gate (
    .addr_i(bus_addr_i), .prog_i(prog_q), .blocked_o(blocked)
  );

  assign acc = bus_req_i & bus_rdy_o;

  sdmr_cmd_fsm #(.OFS_W(OFS_W)) u_fsm (
    .clk(clk), .rst(rst),
    .go_i(acc & bus_we_i & win_hit & ofs_ok),
    .area_i(win_area), .val_i(win_val), .ack_i(mrs_ack_i),
    .blk_i(acc & ~win_hit & blocked),
    .rdy_o(bus_rdy_o), .err_o(bus_err_o), .req_o(mrs_req_o),
    .area_o(mrs_area_o), .val_o(mrs_val_o), .prog_o(prog_q)
  );

  assign fwd_req_o   = acc & ~win_hit & ~blocked;
  assign fwd_we_o    = bus_we_i;
  assign fwd_addr_o  = bus_addr_i;
  assign fwd_wdata_o = bus_wdata_i;
endmodule

// File: rtl/sdmr_chk.sv
module sdmr_chk
  import sdmr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W = 12,
  parameter int AREA_SH = 26,
  parameter logic [N_AREA-1:0][ADDR_W-1:0] WIN_BASE = {32'hFFFF_E000, 32'hFFFF_D000},
  parameter logic [N_AREA-1:0][ADDR_W-1:0] AREA_BASE = {32'h0C00_0000, 32'h0800_0000}
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rdy_o,
  input logic              fwd_req_o,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              mrs_req_o,
  input logic [OFS_W-1:0]  mrs_val_o,
  input logic              mrs_ack_i,
  input logic              wide_q,
  input logic [N_AREA-1:0] prog_q
);
  // R7
  mrs_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mrs_req_o |=> !mrs_req_o);
  // R7
  rdy_low_chk: assert property (@(posedge clk) disable iff (rst)
    mrs_req_o |-> !bus_rdy_o);
  // R7
  rdy_back_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rdy_o && mrs_ack_i) |=> bus_rdy_o);
  // R3
  val_align_chk: assert property (@(posedge clk) disable iff (rst)
    mrs_req_o |-> mrs_val_o == (wide_q ? ($past(bus_addr_i[OFS_W-1:0]) >> 2)
                                        : ($past(bus_addr_i[OFS_W-1:0]) >> 1)));
  // R4
  wide_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(wide_q));

  for (genvar k = 0; k < N_AREA; k++) begin : g_k
    // R6
    win_nofwd_chk: assert property (@(posedge clk) disable iff (rst)
      fwd_req_o |-> bus_addr_i[ADDR_W-1:OFS_W] != WIN_BASE[k][ADDR_W-1:OFS_W]);
    // R8
    blk_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (fwd_req_o && bus_addr_i[ADDR_W-1:AREA_SH] == AREA_BASE[k][ADDR_W-1:AREA_SH])
        |-> prog_q[k]);
  end
endmodule

bind sdmr_mrs_dec sdmr_chk u_chk (
  .clk(clk), .rst(rst), .bus_rdy_o(bus_rdy_o), .fwd_req_o(fwd_req_o),
  .bus_addr_i(bus_addr_i), .mrs_req_o(mrs_req_o), .mrs_val_o(mrs_val_o),
  .mrs_ack_i(mrs_ack_i), .wide_q(wide_q), .prog_q(prog_q)
);

// File: tb/sim_sdmr_mrs_dec.sv
module sim_sdmr_mrs_dec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide = 1'b1;
  logic        req = 1'b0, we = 1'b0, ack = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        rdy, err, f_req, f_we, m_req;
  logic [31:0] f_addr, f_wdata;
  logic [0:0]  m_area;
  logic [11:0] m_val;
  logic        s_freq;
  logic [31:0] s_faddr, s_fdata;
  logic        s_fwe;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdmr_mrs_dec u0 (
    .clk(clk), .rst(rst), .bus_wide_i(wide), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdy_o(rdy), .bus_err_o(err),
    .fwd_req_o(f_req), .fwd_we_o(f_we), .fwd_addr_o(f_addr), .fwd_wdata_o(f_wdata),
    .mrs_req_o(m_req), .mrs_area_o(m_area), .mrs_val_o(m_val), .mrs_ack_i(ack)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic        area;
    logic [11:0] val;
  } vec_t;

  localparam vec_t VT[5] = '{
    '{32'hFFFF_D8C0, 32'h1234_5678, 1'b0, 12'h230},
    '{32'hFFFF_E8C0, 32'hFFFF_FFFF, 1'b1, 12'h230},
    '{32'hFFFF_D000, 32'hA5A5_A5A5, 1'b0, 12'h000},
    '{32'hFFFF_DFFC, 32'h0000_0000, 1'b0, 12'h3FF},
    '{32'hFFFF_E004, 32'h0000_0230, 1'b1, 12'h001}
  };

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // one-cycle access; forward outputs captured mid-cycle
  task automatic bus(logic [31:0] a, logic w, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    s_freq = f_req; s_fwe = f_we; s_faddr = f_addr; s_fdata = f_wdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 rdy", rdy, 1);
    chk("R1 mrs_req", m_req, 0);
    chk("R1 err", err, 0);

    // R8 both areas blocked before programming
    bus(32'h0800_0010, 1'b0, 0);
    chk("R8 no fwd area0", s_freq, 0);
    chk("R8 err pulse", err, 1);
    @(negedge clk);
    chk("R8 err one cycle", err, 0);
    bus(32'h0C00_0100, 1'b1, 32'h55);
    chk("R8 no fwd area1", s_freq, 0);
    chk("R8 err area1", err, 1);

    // R9 passthrough
    bus(32'h2000_0040, 1'b1, 32'hCAFE_F00D);
    chk("R9 fwd req", s_freq, 1);
    chk("R9 fwd addr", s_faddr, 32'h2000_0040);
    chk("R9 fwd data", s_fdata, 32'hCAFE_F00D);
    chk("R9 fwd we", s_fwe, 1);
    chk("R9 no err", err, 0);

    // R5 offset above limit
    bus(32'hFFFF_DFFD, 1'b1, 0);
    chk("R5 no fwd", s_freq, 0);
    chk("R5 no cmd", m_req, 0);
    chk("R5 rdy", rdy, 1);

    // R6 read of a window
    bus(32'hFFFF_D8C0, 1'b0, 0);
    chk("R6 no fwd", s_freq, 0);
    chk("R6 no cmd", m_req, 0);
    chk("R6 rdy", rdy, 1);

    // program area 0 only, then check gating per area
    bus(32'hFFFF_D8C0, 1'b1, 32'hDEAD_BEEF);
    chk("R2 area code", m_area, 0);
    chk("R3 val", m_val, 12'h230);
    do_ack();
    chk("R7 rdy after ack", rdy, 1);
    bus(32'h0800_0010, 1'b0, 0);
    chk("R8 area0 now fwd", s_freq, 1);
    bus(32'h0C00_0010, 1'b0, 0);
    chk("R8 area1 still blocked", s_freq, 0);
    chk("R8 area1 err", err, 1);

    // vector table, acknowledge delayed by entry index
    for (int i = 0; i < 5; i++) begin
      bus(VT[i].a, 1'b1, VT[i].d);
      chk("R7 req", m_req, 1);
      chk("R7 rdy low", rdy, 0);
      chk("R2 area", m_area, VT[i].area);
      chk("R3 value", m_val, VT[i].val);
      for (int j = 0; j < i; j++) begin
        @(negedge clk);
        chk("R7 req one cycle", m_req, 0);
        chk("R7 rdy held", rdy, 0);
      end
      do_ack();
      chk("R7 rdy return", rdy, 1);
    end
    bus(32'h0C00_0010, 1'b1, 32'h77);
    chk("R8 area1 fwd after ack", s_freq, 1);

    // R4 narrow bus; select changed after reset has no effect
    wide = 1'b0;
    do_reset();
    wide = 1'b1;
    bus(32'h0800_0010, 1'b0, 0);
    chk("R1 flags cleared", s_freq, 0);
    bus(32'hFFFF_D8C0, 1'b1, 0);
    chk("R4 narrow val", m_val, 12'h460);
    do_ack();
    bus(32'hFFFF_EFFC, 1'b1, 0);
    chk("R4 narrow area1 val", m_val, 12'h7FE);
    chk("R4 area1 code", m_area, 1);
    do_ack();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule